// File: doc/BRIEF.md
# Two-Stage Pipelined Register Renamer

This block maps the architectural register names of a group of up to IW instructions to physical register names, one group per clock, across two clocked stages. In stage 1 it compares the group's architectural names with each other and with the group one stage ahead. It also launches the mapping-table reads and binds fresh physical names from a free-name supply. In stage 2 the reads complete and the table is updated with the group's new mappings. For every source and every destination, stage 2 picks the final physical name from one of three places: the table, an older producer in the same group, or a producer in the group that went through stage 1 one edge earlier.

The mapping table is read with a registered, read-before-write port. A group therefore sees only the updates made two groups back, and the group directly ahead is covered by a bypass. A table read that a dependency makes useless is not performed. A running count of such skipped reads is exposed. Slot 0 is the oldest instruction of a group. Every instruction has two sources and an optional destination.

Top module: `regren_pipe`

## Requirements
- R1: A group accepted at a clock edge (in_valid and in_ready both high) appears with out_valid high after the second following edge. After reset, out_valid is 0 and reads_skipped is 0.
- R2: A source with no matching producer reads the table. After reset, architectural register r maps to physical register r.
- R3: A source whose architectural name is written by an older enabled slot of its own group receives the new physical name of the youngest such slot.
- R4: A source with no in-group producer, whose name is written by the group accepted on the immediately preceding edge, receives the new name of the youngest matching slot of that group.
- R5: When several slots of a group write the same architectural register, only the youngest one's name is kept in the table, and later groups read that name.
- R6: out_pold of an enabled destination gives the mapping that was in force before the slot. It is taken from the youngest older same-group writer if there is one, otherwise from the youngest writer in the preceding group, otherwise from the table.
- R7: The k-th enabled destination of a group, counting from slot 0, receives free_names[k]. free_pop equals the number of enabled destinations at the accepting edge and 0 otherwise. A disabled destination outputs 0 on both out_pdst and out_pold.
- R8: in_ready is low exactly when free_avail is smaller than the number of enabled destinations. A group that is not accepted consumes no names, and it leaves out_valid low two edges later.
- R9: reads_skipped grows, one edge after acceptance, by the number of sources with any in-group or preceding-group match plus the number of enabled destinations with such a match. It does not change on other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A group is offered |
| in_ready | output | 1 | Enough free names for the offered group |
| in_src1 | input | IW*AW | First source architectural name per slot |
| in_src2 | input | IW*AW | Second source architectural name per slot |
| in_dst | input | IW*AW | Destination architectural name per slot |
| in_dst_en | input | IW | Slot has a destination |
| free_avail | input | FCW | Free names available (saturated at IW) |
| free_names | input | IW*PW | Next free physical names, index 0 first |
| free_pop | output | FCW | Names consumed this edge |
| out_valid | output | 1 | Renamed group valid |
| out_psrc1 | output | IW*PW | Physical name of first source |
| out_psrc2 | output | IW*PW | Physical name of second source |
| out_pdst | output | IW*PW | New physical name of destination |
| out_pold | output | IW*PW | Previous mapping of destination |
| reads_skipped | output | CNT_W | Running count of suppressed table reads |

## Verification
The bench builds the block with IW=4, only 8 architectural registers and 64 physical registers. With so few architectural names, random back-to-back groups are dense with same-group chains, cross-group bypasses and repeated writes to one register. The free-name count is varied between 0 and 4, which exercises stalls with one group in flight, bubbles between groups, and resumption after a bubble, when a prior group's write is already in the table. Every output is compared with a sequential one-slot-at-a-time model, and the skip count is predicted from the matches.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Index of the highest set bit in the low n bits, or -1 if none.
  function automatic int youngest_hit(input logic [31:0] v, input int n);
    int r;
    r = -1;
    for (int k = 0; k < n; k++) if (v[k]) r = k;
    return r;
  endfunction
endpackage

// File: rtl/rn_depcheck.sv
module rn_depcheck #(
  parameter int IW = 4,
  parameter int AW = 5
) (
  input  logic [IW-1:0][AW-1:0] src1,
  input  logic [IW-1:0][AW-1:0] src2,
  input  logic [IW-1:0][AW-1:0] dst,
  input  logic [IW-1:0]         dst_en,
  input  logic                  prev_v,
  input  logic [IW-1:0][AW-1:0] prev_dst,
  input  logic [IW-1:0]         prev_en,
  output logic [IW-1:0][IW-1:0] s1_cur,
  output logic [IW-1:0][IW-1:0] s1_prev,
  output logic [IW-1:0][IW-1:0] s2_cur,
  output logic [IW-1:0][IW-1:0] s2_prev,
  output logic [IW-1:0][IW-1:0] d_cur,
  output logic [IW-1:0][IW-1:0] d_prev,
  output logic [IW-1:0]         wr_kill
);
  logic [IW-1:0][IW-1:0] kill_m;

  for (genvar i = 0; i < IW; i++) begin : g_slot
    for (genvar j = 0; j < IW; j++) begin : g_other
      // older producers in this group (j < i)
      assign s1_cur[i][j]  = (j < i) && dst_en[j] && (dst[j] == src1[i]);
      assign s2_cur[i][j]  = (j < i) && dst_en[j] && (dst[j] == src2[i]);
      assign d_cur[i][j]   = (j < i) && dst_en[i] && dst_en[j] && (dst[j] == dst[i]);
      // producers in the group one stage ahead
      assign s1_prev[i][j] = prev_v && prev_en[j] && (prev_dst[j] == src1[i]);
      assign s2_prev[i][j] = prev_v && prev_en[j] && (prev_dst[j] == src2[i]);
      assign d_prev[i][j]  = prev_v && dst_en[i] && prev_en[j] && (prev_dst[j] == dst[i]);
      // younger writer of the same register overrides this slot's update
      assign kill_m[i][j]  = (j > i) && dst_en[j] && (dst[j] == dst[i]);
    end
    assign wr_kill[i] = |kill_m[i];
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ENTRIES = 32,
  parameter int PW      = 6,
  parameter int NRD     = 12,
  parameter int NWR     = 4,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NRD-1:0]         rd_en,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0][PW-1:0] rd_data,
  input  logic [NWR-1:0]         wr_en,
  input  logic [NWR-1:0][AW-1:0] wr_addr,
  input  logic [NWR-1:0][PW-1:0] wr_data
);
  logic [PW-1:0] tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) tbl[e] <= PW'(e);
    end else begin
      for (int w = 0; w < NWR; w++)
        if (wr_en[w]) tbl[wr_addr[w]] <= wr_data[w];
    end
  end

  // Registered read ports, read-before-write; a disabled port holds its data.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      for (int p = 0; p < NRD; p++)
        if (rd_en[p]) rd_data[p] <= tbl[rd_addr[p]];
    end
  end

  for (genvar a = 0; a < NWR; a++) begin : g_wa
    for (genvar b = a + 1; b < NWR; b++) begin : g_wb
      // R5: at most one write port targets an entry in a cycle
      assert_single_writer_R5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en[a] && wr_en[b] && (wr_addr[a] == wr_addr[b])));
    end
  end
endmodule

// File: rtl/rn_select.sv
module rn_select #(
  parameter int IW = 4,
  parameter int PW = 6
) (
  input  logic [IW-1:0]         cur_hit,
  input  logic [IW-1:0]         prev_hit,
  input  logic [IW-1:0][PW-1:0] cur_names,
  input  logic [IW-1:0][PW-1:0] prev_names,
  input  logic [PW-1:0]         tbl_val,
  output logic [PW-1:0]         pick
);
  int cur_i, prev_i;

  always_comb begin
    cur_i  = rn_pkg::youngest_hit(32'(cur_hit), IW);
    prev_i = rn_pkg::youngest_hit(32'(prev_hit), IW);
    if (cur_i >= 0)       pick = cur_names[cur_i];
    else if (prev_i >= 0) pick = prev_names[prev_i];
    else                  pick = tbl_val;
  end
endmodule

// File: rtl/regren_pipe.sv
module regren_pipe #(
  parameter int IW        = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  parameter int CNT_W     = 16,
  localparam int AW       = $clog2(ARCH_REGS),
  localparam int PW       = $clog2(PHYS_REGS),
  localparam int FCW      = $clog2(IW + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [IW-1:0][AW-1:0] in_src1,
  input  logic [IW-1:0][AW-1:0] in_src2,
  input  logic [IW-1:0][AW-1:0] in_dst,
  input  logic [IW-1:0]         in_dst_en,
  input  logic [FCW-1:0]        free_avail,
  input  logic [IW-1:0][PW-1:0] free_names,
  output logic [FCW-1:0]        free_pop,
  output logic                  out_valid,
  output logic [IW-1:0][PW-1:0] out_psrc1,
  output logic [IW-1:0][PW-1:0] out_psrc2,
  output logic [IW-1:0][PW-1:0] out_pdst,
  output logic [IW-1:0][PW-1:0] out_pold,
  output logic [CNT_W-1:0]      reads_skipped
);
  localparam int NRD = 3 * IW;

  // ---------------- stage 1 ----------------
  int need_cnt, skip_now;
  logic accept;
  logic [IW-1:0][PW-1:0] new_pdst;
  logic [IW-1:0][IW-1:0] s1_cur, s1_prev, s2_cur, s2_prev, d_cur, d_prev;
  logic [IW-1:0]         wr_kill;
  logic [NRD-1:0]         rd_en;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][PW-1:0] rd_data;

  // stage 2 registers
  logic                  v2;
  logic [IW-1:0][AW-1:0] dst2;
  logic [IW-1:0]         en2, kill2;
  logic [IW-1:0][PW-1:0] pdst2, prev_pdst2;
  logic [IW-1:0][IW-1:0] s1c2, s1p2, s2c2, s2p2, dc2, dp2;

  assign need_cnt = $countones(in_dst_en);
  assign in_ready = need_cnt <= int'(free_avail);
  assign accept   = in_valid && in_ready;
  assign free_pop = accept ? FCW'(need_cnt) : '0;

  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < IW; i++) begin
      new_pdst[i] = '0;
      if (in_dst_en[i]) begin
        new_pdst[i] = free_names[k];
        k++;
      end
    end
  end

  rn_depcheck #(.IW(IW), .AW(AW)) u_dep (
    .src1(in_src1), .src2(in_src2), .dst(in_dst), .dst_en(in_dst_en),
    .prev_v(v2), .prev_dst(dst2), .prev_en(en2),
    .s1_cur(s1_cur), .s1_prev(s1_prev), .s2_cur(s2_cur), .s2_prev(s2_prev),
    .d_cur(d_cur), .d_prev(d_prev), .wr_kill(wr_kill)
  );

  // Read gating: a read is launched only when no comparator of its operand matched.
  for (genvar i = 0; i < IW; i++) begin : g_rd
    assign rd_en[i]          = accept && !(|s1_cur[i] || |s1_prev[i]);
    assign rd_en[IW + i]     = accept && !(|s2_cur[i] || |s2_prev[i]);
    assign rd_en[2 * IW + i] = accept && in_dst_en[i] && !(|d_cur[i] || |d_prev[i]);
    assign rd_addr[i]          = in_src1[i];
    assign rd_addr[IW + i]     = in_src2[i];
    assign rd_addr[2 * IW + i] = in_dst[i];
  end

  always_comb begin
    skip_now = 0;
    for (int i = 0; i < IW; i++) begin
      if (|s1_cur[i] || |s1_prev[i]) skip_now++;
      if (|s2_cur[i] || |s2_prev[i]) skip_now++;
      if (|d_cur[i] || |d_prev[i])   skip_now++;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2            <= 1'b0;
      reads_skipped <= '0;
      dst2 <= '0; en2 <= '0; kill2 <= '0; pdst2 <= '0; prev_pdst2 <= '0;
      s1c2 <= '0; s1p2 <= '0; s2c2 <= '0; s2p2 <= '0; dc2 <= '0; dp2 <= '0;
    end else begin
      v2 <= accept;
      if (accept) begin
        reads_skipped <= reads_skipped + CNT_W'(skip_now);
        dst2       <= in_dst;
        en2        <= in_dst_en;
        kill2      <= wr_kill;
        pdst2      <= new_pdst;
        prev_pdst2 <= pdst2;
        s1c2 <= s1_cur; s1p2 <= s1_prev;
        s2c2 <= s2_cur; s2p2 <= s2_prev;
        dc2  <= d_cur;  dp2  <= d_prev;
      end
    end
  end

  // ---------------- table ----------------
  logic [IW-1:0] wr_en;
  for (genvar i = 0; i < IW; i++) begin : g_wr
    assign wr_en[i] = v2 && en2[i] && !kill2[i];
  end

  rn_map_table #(.ENTRIES(ARCH_REGS), .PW(PW), .NRD(NRD), .NWR(IW)) u_tbl (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(dst2), .wr_data(pdst2)
  );

  // ---------------- stage 2 ----------------
  logic [IW-1:0][PW-1:0] sel1, sel2, selo;
  for (genvar i = 0; i < IW; i++) begin : g_sel
    rn_select #(.IW(IW), .PW(PW)) u_s1 (
      .cur_hit(s1c2[i]), .prev_hit(s1p2[i]), .cur_names(pdst2),
      .prev_names(prev_pdst2), .tbl_val(rd_data[i]), .pick(sel1[i]));
    rn_select #(.IW(IW), .PW(PW)) u_s2 (
      .cur_hit(s2c2[i]), .prev_hit(s2p2[i]), .cur_names(pdst2),
      .prev_names(prev_pdst2), .tbl_val(rd_data[IW + i]), .pick(sel2[i]));
    rn_select #(.IW(IW), .PW(PW)) u_so (
      .cur_hit(dc2[i]), .prev_hit(dp2[i]), .cur_names(pdst2),
      .prev_names(prev_pdst2), .tbl_val(rd_data[2 * IW + i]), .pick(selo[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_psrc1 <= '0; out_psrc2 <= '0; out_pdst <= '0; out_pold <= '0;
    end else begin
      out_valid <= v2;
      for (int i = 0; i < IW; i++) begin
        out_psrc1[i] <= sel1[i];
        out_psrc2[i] <= sel2[i];
        out_pdst[i]  <= en2[i] ? pdst2[i] : '0;
        out_pold[i]  <= en2[i] ? selo[i]  : '0;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 out_valid);
  assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> ##1 !out_valid);
  assert_pop_bound_R7: assert property (@(posedge clk) disable iff (rst)
    free_pop <= free_avail);
  assert_skip_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(reads_skipped));
endmodule

// File: tb/sim_regren_pipe.sv
module sim_regren_pipe;
  localparam int IW = 4, ARCH = 8, PHYS = 64, CNT_W = 16;
  localparam int AW = $clog2(ARCH), PW = $clog2(PHYS), FCW = $clog2(IW + 1);

  typedef struct packed {
    bit                    v;
    logic [3:0]            vtag;
    logic [IW-1:0]         en;
    logic [IW-1:0][PW-1:0] s1, s2, pd, po;
    logic [IW-1:0][3:0]    t1, t2;
  } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [IW-1:0][AW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [IW-1:0] in_dst_en = '0;
  logic [FCW-1:0] free_avail = '0, free_pop;
  logic [IW-1:0][PW-1:0] free_names = '0;
  logic out_valid;
  logic [IW-1:0][PW-1:0] out_psrc1, out_psrc2, out_pdst, out_pold;
  logic [CNT_W-1:0] reads_skipped;

  regren_pipe #(.IW(IW), .ARCH_REGS(ARCH), .PHYS_REGS(PHYS), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .in_dst_en(in_dst_en),
    .free_avail(free_avail), .free_names(free_names), .free_pop(free_pop),
    .out_valid(out_valid), .out_psrc1(out_psrc1), .out_psrc2(out_psrc2),
    .out_pdst(out_pdst), .out_pold(out_pold), .reads_skipped(reads_skipped));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  item_t q[$];
  int ref_tbl [ARCH];
  bit written [ARCH];
  int fl_head = 0, exp_skip = 0;
  bit prev_acc = 0;
  logic [IW-1:0][AW-1:0] prev_d = '0;
  logic [IW-1:0] prev_en = '0;

  task automatic chk(input bit ok, input int rq, input longint got, input longint exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: got %0d expected %0d", rq, what, got, exp);
    end
  endtask

  // Classify where an operand's name should come from: R3 same group, R4 preceding group,
  // R5 table holding an updated mapping, R2 table at its reset mapping.
  function automatic int cls(input logic [AW-1:0] a, input int i,
                             input logic [IW-1:0][AW-1:0] d, input logic [IW-1:0] en);
    for (int j = 0; j < i; j++) if (en[j] && d[j] == a) return 3;
    if (prev_acc) for (int j = 0; j < IW; j++) if (prev_en[j] && prev_d[j] == a) return 4;
    return written[a] ? 5 : 2;
  endfunction

  task automatic step(input bit v, input logic [IW-1:0][AW-1:0] s1, input logic [IW-1:0][AW-1:0] s2,
                      input logic [IW-1:0][AW-1:0] d, input logic [IW-1:0] en, input int avail);
    item_t it;
    int need, k, c, skip, nm;
    bit rdy, acc;
    @(negedge clk);
    in_valid = v; in_src1 = s1; in_src2 = s2; in_dst = d; in_dst_en = en;
    free_avail = FCW'(avail);
    for (int n = 0; n < IW; n++) free_names[n] = PW'(8 + ((fl_head + n) % 56));
    #1;
    need = $countones(en);
    rdy = (need <= avail);
    acc = v && rdy;
    chk(in_ready === rdy, 8, in_ready, rdy, "in_ready");
    chk(free_pop === FCW'(acc ? need : 0), 7, free_pop, acc ? need : 0, "free_pop");
    it = '0; it.v = acc; it.vtag = (v && !rdy) ? 4'd8 : 4'd1; it.en = en;
    skip = 0; k = 0;
    if (acc) begin
      for (int i = 0; i < IW; i++) begin
        c = cls(s1[i], i, d, en); it.t1[i] = 4'(c); it.s1[i] = PW'(ref_tbl[s1[i]]);
        if (c == 3 || c == 4) skip++;
        c = cls(s2[i], i, d, en); it.t2[i] = 4'(c); it.s2[i] = PW'(ref_tbl[s2[i]]);
        if (c == 3 || c == 4) skip++;
        if (en[i]) begin
          nm = 8 + ((fl_head + k) % 56); k++;
          c = cls(d[i], i, d, en);
          if (c == 3 || c == 4) skip++;
          it.po[i] = PW'(ref_tbl[d[i]]);
          it.pd[i] = PW'(nm);
          ref_tbl[d[i]] = nm;
          written[d[i]] = 1'b1;
        end
      end
    end
    @(posedge clk);
    q.push_back(it);
    if (acc) begin
      exp_skip += skip;
      fl_head += need;
    end
    prev_acc = acc; prev_d = d; prev_en = en;
  endtask

  // Monitor: outputs after edge k belong to the item pushed at edge k-1.
  always @(negedge clk) begin
    if (!rst) begin
      chk(reads_skipped === CNT_W'(exp_skip), 9, reads_skipped, exp_skip, "reads_skipped");
      if (q.size() >= 2) begin
        item_t it;
        it = q.pop_front();
        chk(out_valid === it.v, int'(it.vtag), out_valid, it.v, "out_valid");
        if (it.v) begin
          for (int i = 0; i < IW; i++) begin
            chk(out_psrc1[i] === it.s1[i], int'(it.t1[i]), out_psrc1[i], it.s1[i], $sformatf("slot %0d src1", i));
            chk(out_psrc2[i] === it.s2[i], int'(it.t2[i]), out_psrc2[i], it.s2[i], $sformatf("slot %0d src2", i));
            chk(out_pdst[i] === it.pd[i], 7, out_pdst[i], it.pd[i], $sformatf("slot %0d pdst", i));
            chk(out_pold[i] === it.po[i], it.en[i] ? 6 : 7, out_pold[i], it.po[i], $sformatf("slot %0d pold", i));
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, 1, 0, 1, "watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [IW-1:0][AW-1:0] a, b, d;
    logic [IW-1:0] en;
    for (int r = 0; r < ARCH; r++) begin ref_tbl[r] = r; written[r] = 1'b0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 / R9: reset state
    chk(out_valid === 1'b0, 1, out_valid, 0, "out_valid after reset");
    chk(reads_skipped === '0, 9, reads_skipped, 0, "reads_skipped after reset");

    // R2: identity mapping, no destinations, no free names needed
    for (int i = 0; i < IW; i++) begin a[i] = AW'(i); b[i] = AW'(i + 4); d[i] = '0; end
    step(1, a, b, d, '0, 0);
    // R3 + R5: whole group writes register 3, chained sources
    for (int i = 0; i < IW; i++) begin a[i] = 3; b[i] = AW'(i); d[i] = 3; end
    step(1, a, b, d, 4'b1111, 4);
    step(0, a, b, d, '0, 4);
    // R5: after a bubble, table holds the youngest writer's name
    for (int i = 0; i < IW; i++) begin a[i] = 3; b[i] = 3; end
    step(1, a, b, d, 4'b0000, 4);
    // R4 / R6: back-to-back producer then consumer
    d[0] = 1; d[1] = 2; d[2] = 1; d[3] = 5;
    step(1, a, b, d, 4'b1111, 4);
    a[0] = 1; a[1] = 2; a[2] = 5; a[3] = 0; b = '0;
    d[0] = 1; d[1] = 5; d[2] = 6; d[3] = 1;
    step(1, a, b, d, 4'b1011, 4);
    // R8: stall with too few names, then retry
    step(1, a, b, d, 4'b1111, 2);
    step(1, a, b, d, 4'b1111, 4);

    // Random dense traffic
    for (int n = 0; n < 400; n++) begin
      int av;
      for (int i = 0; i < IW; i++) begin
        a[i] = AW'($urandom_range(0, ARCH - 1));
        b[i] = AW'($urandom_range(0, ARCH - 1));
        d[i] = AW'($urandom_range(0, ARCH - 1));
        en[i] = ($urandom_range(0, 3) != 0);
      end
      av = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 4) : 4;
      step($urandom_range(0, 9) != 0, a, b, d, en, av);
    end
    repeat (3) step(0, a, b, d, '0, 4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule